// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits behind an Ethernet MAC and stores each incoming frame in a circular receive region of a local memory. Bytes arrive one per accepted cycle with an end-of-frame marker. The error and address-class flags for a frame are sampled with its final byte. Each frame is stored as a 32-bit little-endian header followed by its bytes, FCS included. The header is written after the last data byte. Once the header is in memory, the block moves its write offset to the next 4-byte boundary past the frame.

Software consumes frames and reports progress through a read-pointer register. The value written is the consumed offset minus 16, and the block adds the 16 back before comparing. An empty flag tells the consumer whether unread frames remain. A write-one-to-clear status register reports completed, bad and dropped frames. A running count of frames lost for lack of space is also kept. A frame that would run into unread data is dropped whole, so a stored frame never makes the ring look empty.

Top module: `rx_ring_writer`

## Requirements
- R1: After a synchronous active-low reset: write offset 0, read-pointer register 0xFFF0, `buf_empty` 1, status 0, missed count 0, `in_ready` 1 and no memory write.
- R2: The stored header has the byte count (FCS included) in bits 31:16 and the receive status in bits 15:0. The status bits are: bit0 good frame, bit1 alignment error, bit2 CRC error, bit3 longer than 1518, bit4 shorter than 60, bit5 symbol error, bit13 broadcast, bit14 own-address match and bit15 multicast. Bit0 is 1 exactly when bits 1 to 5 are all 0.
- R3: Data byte i of a frame starting at offset S goes to byte offset S+4+i, in lane (offset mod 4) of word (offset/4). The header is one full-word write at word S/4, issued after the last data byte.
- R4: The next frame starts at S + ((count + 4 + 3) AND NOT 3), taken modulo the ring size.
- R5: A frame whose bytes pass the end of the ring continues at offset 0.
- R6: Status bit0 (receive-OK) is set in the cycle the header write reaches memory. `in_ready` is low for the two cycles after the last byte is accepted.
- R7: The effective read offset is (register + 16) mod ring size. `buf_empty` is 1 exactly when this offset equals the write offset.
- R8: Frame length limits are checked against the byte count. Runt (bit4) means fewer than 60 bytes and too-long (bit3) means more than 1518.
- R9: A bad frame sets status bit1. With `cfg_keep_bad` at 0 it is discarded and the write offset is unchanged. With `cfg_keep_bad` at 1 it is stored with its error bits and bit0 clear.
- R10: The free space is (read − write) mod ring, or the full ring when the two are equal. A frame whose rounded footprint is not less than the free space is dropped and the write offset is unchanged. The drop sets status bit4 and adds 1 to `miss_cnt`, and no write reaches the word at the read offset.
- R11: Writing 1 to a status bit clears it. A hardware set in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of frame (FCS included) |
| in_err | input | 3 | {symbol, CRC, alignment} errors, sampled with last byte |
| in_kind | input | 3 | {multicast, own address, broadcast}, sampled with last byte |
| cfg_keep_bad | input | 1 | Store bad frames instead of discarding them |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte lane enables |
| mem_addr | output | RING_IDX+12 | Word address |
| mem_wdata | output | 32 | Write data |
| rdp_we | input | 1 | Load the read-pointer register |
| rdp_wdata | input | 16 | Consumed offset minus 16 |
| rdp_q | output | 16 | Read-pointer register contents |
| wr_ptr | output | 16 | Start offset of the next frame |
| buf_empty | output | 1 | No unread frame in the ring |
| sts_clr | input | 1 | Apply `sts_clr_mask` as a write-one-to-clear |
| sts_clr_mask | input | 16 | Status bits to clear |
| sts_q | output | 16 | Status: bit0 OK, bit1 error, bit4 overflow |
| miss_cnt | output | MISS_W | Frames dropped for lack of space |

## Verification
The hardest case to reach is an overflow drop where the frame fits almost entirely, stopping only a few bytes short of the read offset. This case is also where the wrap across the ring end sits. The stimulus first parks the read pointer at the write offset and streams maximum-length frames until a frame straddles offset 0. It then parks the pointer again and fills the ring until exactly 572 bytes remain free. A 600-byte frame must then be rejected without touching the header at the read offset. A 564-byte frame, whose 568-byte footprint is one word short of the free space, must be accepted.

// File: rtl/rrw_pkg.sv
// Shared encodings for the receive ring writer.
// Assumes: header status layout is fixed because software decodes it.
package rrw_pkg;
    typedef enum logic [1:0] {
        ST_RX  = 2'd0,
        ST_HDR = 2'd1,
        ST_CMT = 2'd2
    } rrw_state_e;

    // header status bit positions (decoded by software)
    localparam int HB_OK    = 0;
    localparam int HB_ALIGN = 1;
    localparam int HB_CRC   = 2;
    localparam int HB_LONG  = 3;
    localparam int HB_RUNT  = 4;
    localparam int HB_SYM   = 5;
    localparam int HB_BCAST = 13;
    localparam int HB_PHYS  = 14;
    localparam int HB_MCAST = 15;

    // status register bit positions
    localparam int SB_ROK = 0;
    localparam int SB_ERR = 1;
    localparam int SB_OVF = 4;

    localparam int MIN_LEN   = 60;
    localparam int MAX_LEN   = 1518;
    localparam int HDR_BYTES = 4;
    localparam int PTR_BIAS  = 16;
endpackage

// File: rtl/rrw_hdr.sv
// Builds the 32-bit frame header from the byte count and sampled flags.
// Assumes: inputs are held stable while the header is built and committed.
module rrw_hdr
    import rrw_pkg::*;
(
    input  logic [15:0] byte_cnt,
    input  logic [2:0]  err_flags,   // {sym, crc, align}
    input  logic [2:0]  kind_flags,  // {mcast, phys, bcast}
    output logic [31:0] hdr_word,
    output logic        frame_bad
);
    logic [15:0] st_w;

    // Assemble status half-word and the bad-frame summary.
    always_comb begin
        st_w            = '0;
        st_w[HB_ALIGN]  = err_flags[0];
        st_w[HB_CRC]    = err_flags[1];
        st_w[HB_SYM]    = err_flags[2];
        st_w[HB_RUNT]   = (byte_cnt < 16'(MIN_LEN));
        st_w[HB_LONG]   = (byte_cnt > 16'(MAX_LEN));
        st_w[HB_BCAST]  = kind_flags[0];
        st_w[HB_PHYS]   = kind_flags[1];
        st_w[HB_MCAST]  = kind_flags[2];
        frame_bad       = |{st_w[HB_ALIGN], st_w[HB_CRC], st_w[HB_SYM],
                            st_w[HB_RUNT], st_w[HB_LONG]};
        st_w[HB_OK]     = !frame_bad;
        hdr_word        = {byte_cnt, st_w};
    end
endmodule

// File: rtl/rrw_space.sv
// Free-space and empty computation between write and read offsets.
// Assumes: ring size is 2**OFF_W and both offsets are 4-byte aligned.
module rrw_space #(
    parameter int OFF_W = 13
) (
    input  logic [OFF_W-1:0] wr_off,
    input  logic [OFF_W-1:0] rd_off,
    input  logic [15:0]      frame_idx,
    output logic [OFF_W:0]   free_bytes,
    output logic             byte_fits,
    output logic             ring_empty
);
    localparam logic [OFF_W:0] RING = (OFF_W+1)'(1) << OFF_W;
    logic [OFF_W-1:0] diff_w;

    // Distance from write offset forward to read offset; equal means whole ring.
    always_comb begin
        diff_w     = rd_off - wr_off;
        ring_empty = (rd_off == wr_off);
        free_bytes = ring_empty ? RING : {1'b0, diff_w};
        // header(4) + bytes so far + this byte must leave one word gap
        byte_fits  = ({1'b0, frame_idx} + 17'd9) <= 17'(free_bytes);
    end
endmodule

// File: rtl/rrw_status.sv
// Write-one-to-clear status bits and the missed-frame counter.
// Assumes: set pulses are single-cycle; a set beats a clear in the same cycle.
module rrw_status
    import rrw_pkg::*;
#(
    parameter int MISS_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_ok,
    input  logic              set_err,
    input  logic              set_ovf,
    input  logic              clr_en,
    input  logic [15:0]       clr_mask,
    output logic [15:0]       sts_q,
    output logic [MISS_W-1:0] miss_cnt
);
    localparam logic [15:0] IMPL = (16'd1 << SB_ROK) | (16'd1 << SB_ERR) | (16'd1 << SB_OVF);
    logic [15:0] set_vec;
    logic [15:0] clr_vec;

    // Gather hardware set requests and software clears.
    always_comb begin
        set_vec         = '0;
        set_vec[SB_ROK] = set_ok;
        set_vec[SB_ERR] = set_err;
        set_vec[SB_OVF] = set_ovf;
        clr_vec         = clr_en ? clr_mask : 16'd0;
    end

    // Status register update, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((sts_q & ~clr_vec) | set_vec) & IMPL;
    end

    // Count frames lost to overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)       miss_cnt <= '0;
        else if (set_ovf) miss_cnt <= miss_cnt + 1'b1;
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_ok) |-> sts_q[SB_ROK]);
    assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_en && clr_mask[SB_OVF] && !set_ovf) |-> !sts_q[SB_OVF]);
    assert_miss_tracks_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt != $past(miss_cnt)) |-> sts_q[SB_OVF]);
endmodule

// File: rtl/rx_ring_writer.sv
// Writes received frames into a circular buffer as header + data.
// Assumes: host read pointer is 4-byte aligned (after adding the bias of 16);
// the MAC holds in_err/in_kind valid with the final byte.
module rx_ring_writer
    import rrw_pkg::*;
#(
    parameter int RING_IDX = 0,
    parameter int MISS_W   = 24,
    localparam int OFF_W   = 13 + RING_IDX,
    localparam int WADDR_W = OFF_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    input  logic [2:0]         in_err,
    input  logic [2:0]         in_kind,
    input  logic               cfg_keep_bad,
    output logic               mem_we,
    output logic [3:0]         mem_be,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               rdp_we,
    input  logic [15:0]        rdp_wdata,
    output logic [15:0]        rdp_q,
    output logic [15:0]        wr_ptr,
    output logic               buf_empty,
    input  logic               sts_clr,
    input  logic [15:0]        sts_clr_mask,
    output logic [15:0]        sts_q,
    output logic [MISS_W-1:0]  miss_cnt
);
    rrw_state_e       state_q;
    logic [OFF_W-1:0] wr_off_q;
    logic [OFF_W-1:0] rd_off;
    logic [15:0]      rdp_r;
    logic [15:0]      idx_q;
    logic [15:0]      cnt_q;
    logic [2:0]       err_q;
    logic [2:0]       kind_q;
    logic             drop_q;
    logic             keep_q;
    logic             accept;
    logic             byte_fits;
    logic [OFF_W:0]   free_bytes;
    logic [OFF_W-1:0] byte_addr;
    logic [OFF_W-1:0] next_wr;
    logic [31:0]      hdr_word;
    logic             frame_bad;
    logic             hdr_keep;
    logic             set_ok;
    logic             set_err;
    logic             set_ovf;

    rrw_hdr u_hdr (
        .byte_cnt   (cnt_q),
        .err_flags  (err_q),
        .kind_flags (kind_q),
        .hdr_word   (hdr_word),
        .frame_bad  (frame_bad)
    );

    rrw_space #(.OFF_W(OFF_W)) u_space (
        .wr_off     (wr_off_q),
        .rd_off     (rd_off),
        .frame_idx  (idx_q),
        .free_bytes (free_bytes),
        .byte_fits  (byte_fits),
        .ring_empty (buf_empty)
    );

    rrw_status #(.MISS_W(MISS_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ok   (set_ok),
        .set_err  (set_err),
        .set_ovf  (set_ovf),
        .clr_en   (sts_clr),
        .clr_mask (sts_clr_mask),
        .sts_q    (sts_q),
        .miss_cnt (miss_cnt)
    );

    // Derived addresses, handshake and commit pulses.
    always_comb begin
        in_ready  = (state_q == ST_RX);
        accept    = in_valid && in_ready;
        rd_off    = rdp_r[OFF_W-1:0] + OFF_W'(PTR_BIAS);
        byte_addr = wr_off_q + OFF_W'(HDR_BYTES) + OFF_W'(idx_q);
        next_wr   = wr_off_q + ((OFF_W'(cnt_q) + OFF_W'(HDR_BYTES + 3)) & ~OFF_W'(3));
        hdr_keep  = !drop_q && (!frame_bad || cfg_keep_bad);
        set_ok    = (state_q == ST_CMT) && keep_q && !frame_bad;
        set_err   = (state_q == ST_CMT) && !drop_q && frame_bad;
        set_ovf   = (state_q == ST_CMT) && drop_q;
        wr_ptr    = 16'(wr_off_q);
        rdp_q     = rdp_r;
    end

    // Host read-pointer register, reset one bias below zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdp_r <= 16'hFFF0;
        else if (rdp_we) rdp_r <= rdp_wdata;
    end

    // Frame sequencing: receive bytes, write header, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RX;
            wr_off_q <= '0;
            idx_q    <= '0;
            cnt_q    <= '0;
            err_q    <= '0;
            kind_q   <= '0;
            drop_q   <= 1'b0;
            keep_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_RX: if (accept) begin
                    if (idx_q != 16'hFFFF) idx_q <= idx_q + 16'd1;
                    if (!byte_fits)        drop_q <= 1'b1;
                    if (in_last) begin
                        cnt_q   <= (idx_q == 16'hFFFF) ? idx_q : idx_q + 16'd1;
                        err_q   <= in_err;
                        kind_q  <= in_kind;
                        state_q <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    keep_q  <= hdr_keep;
                    state_q <= ST_CMT;
                end
                ST_CMT: begin
                    if (keep_q) wr_off_q <= next_wr;
                    idx_q   <= '0;
                    drop_q  <= 1'b0;
                    state_q <= ST_RX;
                end
                default: state_q <= ST_RX;
            endcase
        end
    end

    // Registered memory write port: data bytes, then the header word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_be    <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            mem_be <= '0;
            if (state_q == ST_RX && accept && !drop_q && byte_fits) begin
                mem_we    <= 1'b1;
                mem_be    <= 4'b0001 << byte_addr[1:0];
                mem_addr  <= WADDR_W'(byte_addr[OFF_W-1:2]);
                mem_wdata <= {4{in_data}};
            end else if (state_q == ST_HDR && hdr_keep) begin
                mem_we    <= 1'b1;
                mem_be    <= 4'hF;
                mem_addr  <= WADDR_W'(wr_off_q[OFF_W-1:2]);
                mem_wdata <= hdr_word;
            end
        end
    end

    assert_hdr_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 4'hF) |-> (state_q == ST_CMT && !in_ready));
    assert_wr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off_q[1:0] == 2'b00);
    assert_no_false_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_off_q != $past(wr_off_q)) |-> !buf_empty);
    assert_rok_follows_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[SB_ROK]) |-> $past(mem_we && mem_be == 4'hF));
endmodule

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
    localparam int RING = 8192;
    localparam int WADDR_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, cfg_keep_bad = 1'b0;
    logic [7:0] in_data = '0;
    logic [2:0] in_err = '0, in_kind = '0;
    logic in_ready, mem_we, buf_empty;
    logic [3:0] mem_be;
    logic [WADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic rdp_we = 1'b0, sts_clr = 1'b0;
    logic [15:0] rdp_wdata = '0, sts_clr_mask = '0;
    logic [15:0] rdp_q, wr_ptr, sts_q;
    logic [23:0] miss_cnt;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] bmem [0:RING/4+3];

    always #2 clk = ~clk;

    rx_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_err(in_err), .in_kind(in_kind),
        .cfg_keep_bad(cfg_keep_bad), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rdp_we(rdp_we),
        .rdp_wdata(rdp_wdata), .rdp_q(rdp_q), .wr_ptr(wr_ptr), .buf_empty(buf_empty),
        .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .sts_q(sts_q), .miss_cnt(miss_cnt)
    );

    // memory model with byte lanes
    always @(posedge clk) begin
        if (mem_we) begin
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) bmem[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
        end
    end

    // {len16, err3 {sym,crc,align}, kind3 {mcast,phys,bcast}, keep1, store1, status16}
    localparam logic [39:0] VEC [9] = '{
        {16'd64,   3'b000, 3'b001, 1'b0, 1'b1, 16'h2001},
        {16'd60,   3'b000, 3'b010, 1'b0, 1'b1, 16'h4001},
        {16'd1518, 3'b000, 3'b100, 1'b0, 1'b1, 16'h8001},
        {16'd59,   3'b000, 3'b010, 1'b1, 1'b1, 16'h4010},
        {16'd61,   3'b010, 3'b010, 1'b1, 1'b1, 16'h4004},
        {16'd100,  3'b001, 3'b000, 1'b0, 1'b0, 16'h0000},
        {16'd1519, 3'b000, 3'b010, 1'b1, 1'b1, 16'h4008},
        {16'd70,   3'b100, 3'b001, 1'b1, 1'b1, 16'h2020},
        {16'd63,   3'b000, 3'b100, 1'b0, 1'b1, 16'h8001}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    function automatic logic [7:0] rd_byte(input int off);
        logic [31:0] w;
        w = bmem[(off % RING) / 4];
        return w[8*(off % 4) +: 8];
    endfunction

    function automatic logic [31:0] rd_word(input int off);
        return bmem[(off % RING) / 4];
    endfunction

    function automatic int data_miss(input int start, input int len, input logic [7:0] seed);
        int m = 0;
        for (int i = 0; i < len; i++)
            if (rd_byte(start + 4 + i) != pat(seed, i)) m++;
        return m;
    endfunction

    // called at a negedge; returns at the negedge after commit
    task automatic send(input int len, input logic [2:0] err, input logic [2:0] kind,
                        input logic [7:0] seed, input bit clr_at_cmt, output bit rdy_low);
        in_err = err;
        in_kind = kind;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data = pat(seed, i);
            in_last = (i == len - 1);
            @(posedge clk); @(negedge clk);
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        rdy_low = !in_ready;
        @(posedge clk); @(negedge clk);
        rdy_low = rdy_low && !in_ready;
        if (clr_at_cmt) begin
            sts_clr = 1'b1;
            sts_clr_mask = 16'h0001;
        end
        @(posedge clk); @(negedge clk);
        sts_clr = 1'b0;
    endtask

    task automatic clear_sts(input logic [15:0] m);
        sts_clr = 1'b1;
        sts_clr_mask = m;
        @(posedge clk); @(negedge clk);
        sts_clr = 1'b0;
    endtask

    task automatic set_rd(input int off);
        rdp_we = 1'b1;
        rdp_wdata = 16'((off - 16) & 16'hFFFF);
        @(posedge clk); @(negedge clk);
        rdp_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int ew = 0;
        int start;
        bit rdy;
        bit wrapped = 1'b0;
        for (int w = 0; w < RING/4 + 4; w++) bmem[w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(wr_ptr == 16'd0, "R1 wr_ptr", wr_ptr, 0);
        chk(rdp_q == 16'hFFF0, "R1 rdp_q", rdp_q, 16'hFFF0);
        chk(buf_empty == 1'b1, "R1 empty", buf_empty, 1);
        chk(sts_q == 16'd0 && miss_cnt == 24'd0, "R1 status", sts_q, 0);
        chk(in_ready && !mem_we, "R1 ready", in_ready, 1);

        // table walk: R2 R3 R4 R8 R9
        for (int k = 0; k < 9; k++) begin
            logic [39:0] v;
            int len;
            logic [15:0] exps;
            v = VEC[k];
            len = int'(v[39:24]);
            exps = v[15:0];
            cfg_keep_bad = v[17];
            start = ew;
            send(len, v[23:21], v[20:18], 8'(k * 31 + 5), 1'b0, rdy);
            if (k == 0) begin
                chk(rdy, "R6 in_ready low after last", !rdy, 1);
                chk(!buf_empty, "R7 not empty after frame", buf_empty, 0);
            end
            if (v[16]) begin
                chk(rd_word(start) == {v[39:24], exps}, "R2 R8 header",
                    rd_word(start), {v[39:24], exps});
                chk(data_miss(start, len, 8'(k * 31 + 5)) == 0, "R3 data bytes",
                    data_miss(start, len, 8'(k * 31 + 5)), 0);
                ew = (ew + ((len + 7) & ~3)) % RING;
                chk(int'(wr_ptr) == ew, "R4 next start", wr_ptr, ew);
                chk(sts_q[0] == exps[0], "R6 receive-OK bit", sts_q[0], exps[0]);
                chk(sts_q[1] == !exps[0], "R9 error bit", sts_q[1], !exps[0]);
            end else begin
                chk(int'(wr_ptr) == ew, "R9 discarded keeps wr", wr_ptr, ew);
                chk(sts_q[1:0] == 2'b10, "R9 discarded status", sts_q, 2);
            end
            clear_sts(16'hFFFF);
        end

        // wrap: R5, R7, R11
        cfg_keep_bad = 1'b0;
        set_rd(ew);
        chk(buf_empty, "R7 empty when read reaches write", buf_empty, 1);
        for (int f = 0; f < 4; f++) begin
            start = ew;
            send(1518, 3'b000, 3'b010, 8'(f * 13 + 1), f == 3, rdy);
            if (start + 4 + 1518 > RING) wrapped = 1'b1;
            chk(rd_word(start) == {16'd1518, 16'h4001}, "R5 header", rd_word(start), 32'h05EE4001);
            chk(data_miss(start, 1518, 8'(f * 13 + 1)) == 0, "R5 wrapped data",
                data_miss(start, 1518, 8'(f * 13 + 1)), 0);
            ew = (ew + 1524) % RING;
            chk(int'(wr_ptr) == ew, "R5 wr_ptr", wr_ptr, ew);
        end
        chk(wrapped, "R5 a frame crossed the ring end", wrapped, 1);
        chk(sts_q[0], "R11 set wins over clear", sts_q[0], 1);
        clear_sts(16'h0001);
        chk(!sts_q[0], "R11 write-one clears", sts_q[0], 0);
        clear_sts(16'hFFFF);

        // overflow: R10
        set_rd(ew);
        chk(rdp_q == 16'((ew - 16) & 16'hFFFF), "R7 rdp readback", rdp_q, ew - 16);
        start = ew;
        for (int f = 0; f < 5; f++) begin
            send(1518, 3'b000, 3'b010, 8'(f + 40), 1'b0, rdy);
            ew = (ew + 1524) % RING;
        end
        clear_sts(16'hFFFF);
        send(600, 3'b000, 3'b010, 8'h77, 1'b0, rdy);
        chk(int'(wr_ptr) == ew, "R10 dropped keeps wr", wr_ptr, ew);
        chk(sts_q[4] && !sts_q[0], "R10 overflow bit", sts_q, 16'h0010);
        chk(miss_cnt == 24'd1, "R10 missed count", miss_cnt, 1);
        chk(rd_word(start) == {16'd1518, 16'h4001}, "R10 unread header intact",
            rd_word(start), 32'h05EE4001);
        clear_sts(16'h0010);
        chk(sts_q[4] == 1'b0, "R11 clear overflow", sts_q[4], 0);
        send(564, 3'b000, 3'b001, 8'h21, 1'b0, rdy);
        ew = (ew + 568) % RING;
        chk(int'(wr_ptr) == ew && sts_q[0], "R10 tight fit accepted", wr_ptr, ew);
        chk(!buf_empty && miss_cnt == 24'd1, "R10 not empty after tight fit", buf_empty, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule